// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block sits beside a small processor core and tracks two asynchronous hardware interrupt sources: a timer-underflow event (the decrementer), which is edge sensitive, and an external interrupt line, which is level sensitive. It holds a pending vector for both. On a suitable cycle it decides whether one of them may be taken by the core.

Both sources are gated by a single enable bit from the core's machine state register. A decrementer event is remembered while interrupts are masked, and any number of events collapse into one pending interrupt. The external line is never latched. It is taken only if it is still asserted at the moment of delivery, so a pulse that rises and falls while masked is lost. Delivery is evaluated at every instruction boundary and on every write to the machine state register. On delivery the block emits a one-cycle take strobe with a cause code, clears the matching pending bit and asks the core to clear the enable bit.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `pend_o` to 0, `take_o` to 0, `cause_o` to 0 and `clr_ee_o` to 0 at that edge, even if a delivery would otherwise have been made.
- R2: A decrementer event sets `pend_o[1]` (value 2) at the next edge. Any number of events before delivery produce exactly one delivery with cause 2.
- R3: `pend_o[0]` (value 1) shows the external line as sampled at the previous edge. An external interrupt is delivered only if `ext_line_i` is high in the cycle the decision is made.
- R4: An external line that rises and falls while `ee_bit_i` is low is never delivered afterwards.
- R5: No delivery is made in a cycle where `ee_bit_i` is low.
- R6: A delivery decision is made only in a cycle where `insn_boundary_i` or `msr_wr_i` is high. A write to the state register with the enable high delivers a pending source even without a boundary.
- R7: A delivery decided in cycle T shows at the edge that ends T as `take_o`=1 for one cycle, together with `clr_ee_o`=1 and `cause_o` = 1 (external) or 2 (decrementer). `cause_o` is 0 while `take_o` is low.
- R8: When both sources are deliverable, the external one is taken first and `pend_o[1]` stays set.
- R9: A decrementer event that arrives in the same cycle a decrementer delivery is decided leaves `pend_o[1]` set, and the bit is delivered again later.
- R10: No delivery is decided in the cycle in which `take_o` is high, so `take_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_event_i | input | 1 | Decrementer underflow event (one-cycle pulse by default) |
| ext_line_i | input | 1 | External interrupt level, active high |
| ee_bit_i | input | 1 | Current external-interrupt-enable bit of the state register |
| msr_wr_i | input | 1 | State register write strobe; `ee_bit_i` already carries the new value |
| insn_boundary_i | input | 1 | Instruction boundary strobe |
| pend_o | output | 2 | Pending vector: bit 0 external, bit 1 decrementer |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| cause_o | output | CAUSE_W | Cause code: 1 external, 2 decrementer, 0 idle |
| clr_ee_o | output | 1 | Request to clear the enable bit |

## Verification
The hardest case to reach is a decrementer event that lands exactly in the cycle its own pending bit is being delivered and cleared. The bench first builds up a masked decrementer interrupt. It then raises the enable, the boundary strobe and a fresh event in a single step, and checks that the bit survives and is delivered a second time. The lost external pulse is reached in a similar way. The line is raised and dropped under the mask, and the enable then opens while the registered pending bit still shows the stale level.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
   localparam int unsigned SRC_N   = 2;
   localparam int unsigned SRC_EXT = 0;
   localparam int unsigned SRC_DEC = 1;
   typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irq_dec_capture.sv
module irq_dec_capture #(
   parameter bit PULSE_INPUT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic evt_i,
   output logic edge_o
);
   generate
      if (PULSE_INPUT) begin : g_pulse
         assign edge_o = evt_i;
         logic unused_r;
         assign unused_r = clk ^ rst;
      end else begin : g_level
         logic prev_q;
         always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= evt_i;
         end
         assign edge_o = evt_i & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
   import irq_pend_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     ext_line_i,
   input  logic     dec_edge_i,
   input  logic     clr_dec_i,
   output src_vec_t pend_o
);
   logic ext_q, dec_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ext_q <= 1'b0;
         dec_q <= 1'b0;
      end else begin
         ext_q <= ext_line_i;
         dec_q <= (dec_q & ~clr_dec_i) | dec_edge_i;
      end
   end

   assign pend_o[SRC_EXT] = ext_q;
   assign pend_o[SRC_DEC] = dec_q;

   // R9: a new edge always wins over a clear in the same cycle
   assert_edge_sets_R9: assert property (@(posedge clk) disable iff (rst)
      dec_edge_i |=> dec_q);
   // R2: without edge or clear the bit holds
   assert_dec_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!dec_edge_i && !clr_dec_i) |=> $stable(dec_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_pend_pkg::*;
#(
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               check_i,
   input  logic               enable_i,
   input  logic               block_i,
   input  logic               ext_live_i,
   input  logic               dec_pend_i,
   output logic               fire_o,
   output src_vec_t           sel_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic gate;
   assign gate   = check_i & enable_i & ~block_i;
   assign fire_o = gate & (ext_live_i | dec_pend_i);

   always_comb begin
      sel_o = '0;
      if (fire_o) begin
         if (ext_live_i) sel_o[SRC_EXT] = 1'b1;
         else            sel_o[SRC_DEC] = 1'b1;
      end
   end

   assign cause_o = CAUSE_W'(sel_o);

   // R8: at most one source is chosen, external first
   assert_one_source_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_o) && (fire_o == (sel_o != '0)));
   assert_ext_first_R8: assert property (@(posedge clk) disable iff (rst)
      (fire_o && ext_live_i) |-> sel_o[SRC_EXT]);
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned CAUSE_W   = 4,
   parameter bit          DEC_PULSE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               dec_event_i,
   input  logic               ext_line_i,
   input  logic               ee_bit_i,
   input  logic               msr_wr_i,
   input  logic               insn_boundary_i,
   output logic [1:0]         pend_o,
   output logic               take_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               clr_ee_o
);
   generate
      if (CAUSE_W < 2) begin : g_bad_width
         $error("CAUSE_W must be at least 2");
      end
   endgenerate

   logic               dec_edge;
   logic               fire;
   src_vec_t           sel;
   src_vec_t           pend;
   logic [CAUSE_W-1:0] cause_n;
   logic               take_q, clr_q;
   logic [CAUSE_W-1:0] cause_q;

   irq_dec_capture #(.PULSE_INPUT(DEC_PULSE)) u_cap (
      .clk(clk), .rst(rst), .evt_i(dec_event_i), .edge_o(dec_edge));

   irq_pend_state u_state (
      .clk(clk), .rst(rst), .ext_line_i(ext_line_i), .dec_edge_i(dec_edge),
      .clr_dec_i(sel[SRC_DEC]), .pend_o(pend));

   irq_pick #(.CAUSE_W(CAUSE_W)) u_pick (
      .clk(clk), .rst(rst),
      .check_i(insn_boundary_i | msr_wr_i), .enable_i(ee_bit_i),
      .block_i(take_q), .ext_live_i(ext_line_i),
      .dec_pend_i(pend[SRC_DEC]), .fire_o(fire), .sel_o(sel),
      .cause_o(cause_n));

   always_ff @(posedge clk) begin
      if (rst) begin
         take_q  <= 1'b0;
         clr_q   <= 1'b0;
         cause_q <= '0;
      end else begin
         take_q  <= fire;
         clr_q   <= fire;
         cause_q <= fire ? cause_n : '0;
      end
   end

   assign pend_o   = pend;
   assign take_o   = take_q;
   assign clr_ee_o = clr_q;
   assign cause_o  = cause_q;

   assert_gated_R5: assert property (@(posedge clk) disable iff (rst)
      take_o |-> $past(ee_bit_i));
   assert_check_R6: assert property (@(posedge clk) disable iff (rst)
      take_o |-> $past(insn_boundary_i || msr_wr_i));
   assert_ext_live_R3: assert property (@(posedge clk) disable iff (rst)
      (take_o && cause_o == CAUSE_W'(1)) |-> $past(ext_line_i));
   assert_single_R10: assert property (@(posedge clk) disable iff (rst)
      take_o |=> !take_o);
   assert_cause_R7: assert property (@(posedge clk) disable iff (rst)
      take_o ? ($countones(cause_o) == 1 && clr_ee_o) : (cause_o == '0 && !clr_ee_o));
   assert_refire_R9: assert property (@(posedge clk) disable iff (rst)
      (take_o && cause_o == CAUSE_W'(2) && $past(dec_edge)) |-> pend_o[1]);
endmodule

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
   localparam int CW = 4;
   logic clk = 1'b0;
   logic rst, dec, ext, ee, wr, bnd;
   logic [1:0] pend;
   logic take, clr;
   logic [CW-1:0] cause;
   int checks = 0, errors = 0;
   bit done = 1'b0;
   int expq[$];

   always #4 clk = ~clk;

   irq_pend_ctrl #(.CAUSE_W(CW)) u_irq_pend_ctrl (
      .clk(clk), .rst(rst), .dec_event_i(dec), .ext_line_i(ext), .ee_bit_i(ee),
      .msr_wr_i(wr), .insn_boundary_i(bnd), .pend_o(pend), .take_o(take),
      .cause_o(cause), .clr_ee_o(clr));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one step: drive after a falling edge, return at the next falling edge
   task automatic step(input logic d, input logic x, input logic e,
                       input logic w, input logic b);
      dec = d; ext = x; ee = e; wr = w; bnd = b;
      @(negedge clk);
   endtask

   task automatic expect_take(input int c);
      expq.push_back(c);
   endtask

   // monitor: every take is compared against the scoreboard queue
   always @(negedge clk) begin
      if (!rst) begin
         if (take) begin
            if (expq.size() == 0) chk("R7 unexpected take", int'(cause), 0);
            else begin
               chk("R7 cause", int'(cause), expq.pop_front());
               chk("R7 clr_ee with take", int'(clr), 1);
            end
         end else begin
            chk("R7 idle cause", int'(cause), 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; dec = 0; ext = 0; ee = 0; wr = 0; bnd = 0;
      @(negedge clk);
      // R1: reset suppresses a delivery that would otherwise happen
      step(1, 1, 1, 1, 1);
      chk("R1 pend", int'(pend), 0);
      chk("R1 take", int'(take), 0);
      chk("R1 cause", int'(cause), 0);
      chk("R1 clr", int'(clr), 0);
      rst = 1'b0;
      step(0, 0, 0, 0, 0);

      // R2: three masked events collapse into one delivery
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 1);
      chk("R2 pend dec", int'(pend), 2);
      expect_take(2);
      step(0, 0, 1, 0, 1);
      chk("R2 take", int'(take), 1);
      chk("R2 cleared", int'(pend), 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 1);
      step(0, 0, 1, 0, 1);
      chk("R2 no second take", int'(take), 0);
      step(0, 0, 0, 0, 0);

      // R4: masked pulse on the external line is lost
      step(0, 1, 0, 0, 1);
      chk("R3 pend ext", int'(pend), 1);
      step(0, 0, 0, 0, 1);
      chk("R4 pend drops", int'(pend), 0);
      step(0, 0, 1, 0, 1);
      step(0, 0, 1, 1, 1);
      chk("R4 never taken", int'(take), 0);
      step(0, 0, 0, 0, 0);

      // R3: registered pend still high, live line low -> no delivery
      step(0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 1);
      chk("R3 live line required", int'(take), 0);
      step(0, 0, 0, 0, 0);

      // R5, R6: enable low blocks; enable without a check cycle blocks
      step(0, 1, 0, 0, 1);
      step(0, 1, 0, 1, 1);
      chk("R5 masked", int'(take), 0);
      step(0, 1, 1, 0, 0);
      chk("R6 no check cycle", int'(take), 0);
      expect_take(1);
      step(0, 1, 1, 1, 0);
      chk("R6 msr write delivers", int'(take), 1);
      // R10: core has not yet cleared enable; still no second take
      step(0, 1, 1, 0, 1);
      chk("R10 no back-to-back", int'(take), 0);
      step(0, 0, 0, 0, 0);

      // R8: both pending, external first, decrementer stays
      step(1, 1, 0, 0, 0);
      chk("R8 both pend", int'(pend), 3);
      expect_take(1);
      step(0, 1, 1, 0, 1);
      chk("R8 dec kept", int'(pend[1]), 1);
      step(0, 0, 0, 0, 0);
      expect_take(2);
      step(0, 0, 1, 0, 1);
      chk("R8 dec later", int'(take), 1);
      step(0, 0, 0, 0, 0);

      // R9: event arriving in the delivery cycle is kept
      step(1, 0, 0, 0, 0);
      expect_take(2);
      step(1, 0, 1, 0, 1);
      chk("R9 bit kept", int'(pend[1]), 1);
      step(0, 0, 0, 0, 0);
      expect_take(2);
      step(0, 0, 1, 0, 1);
      chk("R9 redelivered", int'(take), 1);
      chk("R9 now clear", int'(pend), 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      chk("R7 scoreboard drained", expq.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule